// File: doc/BRIEF.md
# External Interrupt Edge and Wakeup Controller

This block watches one external interrupt pin plus two groups of wakeup-capable port pins. Each pin first passes through a synchronizer. A small edge-control register then decides what counts as an interrupt trigger on the interrupt pin and what counts as a wakeup condition on each pin group. A qualifying trigger sets a latched request flag. The flag sets whether or not the interrupt source is enabled, and it stays set until software clears it.

The interrupt output to the processor is high whenever three things hold together: the flag is set, the per-source enable is set and the global enable is set. Because of this, a request that was latched while the source was disabled fires as soon as both enables become 1. The wakeup output is combinational from the synchronized pins, so it can be sampled while the core clock is stopped.

Software reaches two byte registers. Address 0 holds the edge control: a mode bit at bit 7 and a two-bit edge select at bits 4:3. Address 1 holds the flags: the request at bit 0, the source enable at bit 1 and the global enable at bit 2. The request flag is a two-state machine with states REQ_IDLE and REQ_PENDING:
- REQ_IDLE moves to REQ_PENDING on the set transition, which fires on any trigger.
- REQ_PENDING moves to REQ_IDLE on the clear transition, which fires on a software clear with no trigger in the same cycle.
- Otherwise the state holds.

Top module: `extint_wake_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, and irq and wakeup are 0 while all pins are high.
- R2: A write to address 0 keeps only bits 7, 4 and 3. Every other bit reads back as zero. Addresses other than 0 and 1 read 0x00.
- R3: With bit 7 of address 0 clear (legacy mode), a falling edge on int_pin sets the request flag exactly three clock edges after the pin changes. A rising edge sets nothing.
- R4: With bit 7 set, the edge select in bits 4:3 chooses the trigger: 2'b01 for rising, 2'b10 for falling, 2'b11 for either edge. The flag appears three clock edges after the pin changes.
- R5: With bit 7 set and an edge select of 2'b00, int_pin produces neither a flag nor a wakeup.
- R6: The request flag sets on a trigger even when the source enable and the global enable are both 0.
- R7: irq is 1 exactly when the request flag, the source enable (bit 1 of address 1) and the global enable (bit 2 of address 1) are all 1. A flag latched earlier raises irq as soon as both enables are written to 1.
- R8: The request flag holds until a write to address 1 with bit 0 equal to 0. A write with bit 0 equal to 1 leaves the flag unchanged.
- R9: When a trigger and a clearing write fall in the same cycle, the flag ends up set.
- R10: In legacy mode, wakeup is 1 while any synchronized pin (int_pin, p0_pins or p1_pins) is low. It rises two clock edges after a pin falls.
- R11: With bit 7 set, wakeup is high for one cycle on any change of a p1_pins bit and on an int_pin trigger. It is also high while any p0_pins bit is low.
- R12: A pin held at its new level after a trigger does not set the flag again once software has cleared it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_pin | input | 1 | External interrupt pin, asynchronous |
| p0_pins | input | P0_W | Group 0 wakeup pins, asynchronous |
| p1_pins | input | P1_W | Group 1 wakeup pins, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both read and write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data, combinational |
| irq | output | 1 | Interrupt request to the processor |
| wakeup | output | 1 | Wakeup request, combinational from synchronized pins |

## Verification
The bench builds the block with P0_W=2, P1_W=3 and SYNC_STAGES=2. These narrow groups let a single pin in each group be driven low or toggled while its neighbours stay high, so any-low and any-change detection can be observed one bit at a time. Keeping two synchronizer stages makes the two-edge wakeup latency and the three-edge flag latency fixed numbers. The bench uses that exact timing to place a clearing write in the very cycle in which a trigger is due.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

    localparam int REG_W          = 8;
    localparam int ADDR_W         = 2;
    localparam int SEL_W          = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd1;

    localparam int CTRL_MODE_BIT  = 7;
    localparam int CTRL_SEL_LSB   = 3;
    localparam int FLAG_REQ_BIT   = 0;
    localparam int FLAG_SRC_BIT   = 1;
    localparam int FLAG_GIE_BIT   = 2;

    localparam logic [REG_W-1:0] CTRL_MASK =
        (REG_W'(1) << CTRL_MODE_BIT) | (REG_W'(3) << CTRL_SEL_LSB);
    localparam logic [REG_W-1:0] EN_MASK =
        (REG_W'(1) << FLAG_SRC_BIT) | (REG_W'(1) << FLAG_GIE_BIT);

    typedef enum logic [2:0] {
        TRIG_OFF,
        TRIG_LEGACY,
        TRIG_RISE,
        TRIG_FALL,
        TRIG_BOTH
    } trig_mode_e;

    typedef enum logic {
        REQ_IDLE,
        REQ_PENDING
    } req_state_e;

    function automatic trig_mode_e decode_mode(input logic mode_bit,
                                               input logic [SEL_W-1:0] sel);
        trig_mode_e m;
        if (!mode_bit) begin
            m = TRIG_LEGACY;
        end else begin
            unique case (sel)
                2'b01:   m = TRIG_RISE;
                2'b10:   m = TRIG_FALL;
                2'b11:   m = TRIG_BOTH;
                default: m = TRIG_OFF;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/ewc_sync.sv
module ewc_sync #(
    parameter int       WIDTH     = 1,
    parameter int       STAGES    = 2,
    parameter logic     RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_in;
        if (g == 0) begin : g_first
            assign stage_in = din;
        end else begin : g_next
            assign stage_in = stage_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= {WIDTH{RESET_VAL}};
            end else begin
                stage_q[g] <= stage_in;
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/ewc_trigger.sv
module ewc_trigger
    import ewc_pkg::*;
#(
    parameter int P0_W = 4,
    parameter int P1_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  trig_mode_e      mode,
    input  logic            int_s,
    input  logic [P0_W-1:0] p0_s,
    input  logic [P1_W-1:0] p1_s,
    output logic            int_trig,
    output logic            wake
);

    logic            int_prev;
    logic [P1_W-1:0] p1_prev;
    logic            int_rise;
    logic            int_fall;
    logic            p0_any_low;
    logic            p1_any_low;
    logic            p1_any_change;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_prev <= 1'b1;
            p1_prev  <= '1;
        end else begin
            int_prev <= int_s;
            p1_prev  <= p1_s;
        end
    end

    assign int_rise      =  int_s & ~int_prev;
    assign int_fall      = ~int_s &  int_prev;
    assign p0_any_low    = ~&p0_s;
    assign p1_any_low    = ~&p1_s;
    assign p1_any_change = |(p1_s ^ p1_prev);

    always_comb begin
        unique case (mode)
            TRIG_LEGACY: int_trig = int_fall;
            TRIG_RISE:   int_trig = int_rise;
            TRIG_FALL:   int_trig = int_fall;
            TRIG_BOTH:   int_trig = int_rise | int_fall;
            default:     int_trig = 1'b0;
        endcase
    end

    always_comb begin
        if (mode == TRIG_LEGACY) begin
            wake = ~int_s | p0_any_low | p1_any_low;
        end else begin
            wake = int_trig | p0_any_low | p1_any_change;
        end
    end

endmodule

// File: rtl/ewc_regs.sv
module ewc_regs
    import ewc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              req_pending,
    output logic [REG_W-1:0]  rd_data,
    output logic              mode_bit,
    output logic [SEL_W-1:0]  edge_sel,
    output logic              src_en,
    output logic              gie,
    output logic              clr_req
);

    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] en_q;
    logic             wr_ctrl;
    logic             wr_flags;

    assign wr_ctrl  = wr_en && (addr == ADDR_CTRL);
    assign wr_flags = wr_en && (addr == ADDR_FLAGS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            en_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= wr_data & CTRL_MASK;
            end
            if (wr_flags) begin
                en_q <= wr_data & EN_MASK;
            end
        end
    end

    assign clr_req  = wr_flags && !wr_data[FLAG_REQ_BIT];
    assign mode_bit = ctrl_q[CTRL_MODE_BIT];
    assign edge_sel = ctrl_q[CTRL_SEL_LSB +: SEL_W];
    assign src_en   = en_q[FLAG_SRC_BIT];
    assign gie      = en_q[FLAG_GIE_BIT];

    always_comb begin
        unique case (addr)
            ADDR_CTRL:  rd_data = ctrl_q;
            ADDR_FLAGS: rd_data = en_q | (REG_W'(req_pending) << FLAG_REQ_BIT);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ewc_req_fsm.sv
module ewc_req_fsm
    import ewc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic clr,
    input  logic src_en,
    input  logic gie,
    output logic pending,
    output logic irq
);

    req_state_e state_q;
    req_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: begin
                if (trig) state_d = REQ_PENDING;
            end
            REQ_PENDING: begin
                if (clr && !trig) state_d = REQ_IDLE;
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == REQ_PENDING);
        irq     = pending && src_en && gie;
    end

    a_r6_trigger_sets: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pending);
    a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr) |=> pending);
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !trig) |=> !pending);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && clr) |=> pending);

endmodule

// File: rtl/extint_wake_ctrl.sv
module extint_wake_ctrl
    import ewc_pkg::*;
#(
    parameter int P0_W        = 4,
    parameter int P1_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  int_pin,
    input  logic [P0_W-1:0]       p0_pins,
    input  logic [P1_W-1:0]       p1_pins,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [REG_W-1:0]      wr_data,
    output logic [REG_W-1:0]      rd_data,
    output logic                  irq,
    output logic                  wakeup
);

    localparam int PIN_W = 1 + P0_W + P1_W;

    logic [PIN_W-1:0] pins_s;
    logic             int_s;
    logic [P0_W-1:0]  p0_s;
    logic [P1_W-1:0]  p1_s;
    logic             mode_bit;
    logic [SEL_W-1:0] edge_sel;
    trig_mode_e       mode;
    logic             src_en;
    logic             gie;
    logic             clr_req;
    logic             int_trig;
    logic             req_pending;

    ewc_sync #(
        .WIDTH     (PIN_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({p1_pins, p0_pins, int_pin}),
        .dout (pins_s)
    );

    assign int_s = pins_s[0];
    assign p0_s  = pins_s[1 +: P0_W];
    assign p1_s  = pins_s[1 + P0_W +: P1_W];

    ewc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .req_pending(req_pending),
        .rd_data    (rd_data),
        .mode_bit   (mode_bit),
        .edge_sel   (edge_sel),
        .src_en     (src_en),
        .gie        (gie),
        .clr_req    (clr_req)
    );

    assign mode = decode_mode(mode_bit, edge_sel);

    ewc_trigger #(
        .P0_W(P0_W),
        .P1_W(P1_W)
    ) u_trigger (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .int_s   (int_s),
        .p0_s    (p0_s),
        .p1_s    (p1_s),
        .int_trig(int_trig),
        .wake    (wakeup)
    );

    ewc_req_fsm u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (int_trig),
        .clr    (clr_req),
        .src_en (src_en),
        .gie    (gie),
        .pending(req_pending),
        .irq    (irq)
    );

    a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_OFF && !req_pending) |=> !req_pending);
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (req_pending && src_en && gie));
    a_r3_legacy_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_LEGACY && int_s && !req_pending) |=> !req_pending);

endmodule

// File: tb/extint_wake_ctrl_bench.sv
module extint_wake_ctrl_bench;

    localparam int P0_W = 2;
    localparam int P1_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            int_pin = 1'b1;
    logic [P0_W-1:0] p0_pins = '1;
    logic [P1_W-1:0] p1_pins = '1;
    logic            wr_en = 1'b0;
    logic [1:0]      addr = 2'd0;
    logic [7:0]      wr_data = 8'h00;
    logic [7:0]      rd_data;
    logic            irq;
    logic            wakeup;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    extint_wake_ctrl #(
        .P0_W(P0_W), .P1_W(P1_W), .SYNC_STAGES(2)
    ) u_extint_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .int_pin(int_pin), .p0_pins(p0_pins),
        .p1_pins(p1_pins), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .wakeup(wakeup)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    function automatic logic [7:0] flag_bit(input logic [7:0] v);
        return {7'd0, v[0]};
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1 flags", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 wakeup", {7'd0, wakeup}, 8'h00);
    endtask

    task automatic t_ctrl_rw();
        logic [7:0] v;
        wr(2'd0, 8'hFF);
        rd(2'd0, v); chk("R2 ctrl mask", v, 8'h98);
        rd(2'd3, v); chk("R2 unmapped", v, 8'h00);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R2 ctrl cleared", v, 8'h00);
    endtask

    task automatic t_legacy_int();
        logic [7:0] v;
        int_pin = 1'b0;
        tick(1); chk("R10 wake not before sync", {7'd0, wakeup}, 8'h00);
        tick(1); chk("R10 wake on low", {7'd0, wakeup}, 8'h01);
        rd(2'd1, v); chk("R3 flag not yet", flag_bit(v), 8'h00);
        tick(1); rd(2'd1, v); chk("R3 R6 flag on fall, enables off", flag_bit(v), 8'h01);
        chk("R7 no irq when disabled", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'h00);
        tick(3); rd(2'd1, v); chk("R12 held low no retrigger", flag_bit(v), 8'h00);
        int_pin = 1'b1;
        tick(3); rd(2'd1, v); chk("R3 rise ignored", flag_bit(v), 8'h00);
        chk("R10 wake released", {7'd0, wakeup}, 8'h00);
    endtask

    task automatic t_irq_gate();
        logic [7:0] v;
        int_pin = 1'b0; tick(3); int_pin = 1'b1; tick(3);
        wr(2'd1, 8'h01);
        rd(2'd1, v); chk("R8 write one keeps flag", flag_bit(v), 8'h01);
        chk("R7 irq off no enables", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'h03);
        chk("R7 irq off no global", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'h05);
        chk("R7 irq off no source", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'h07);
        chk("R7 late enable fires", {7'd0, irq}, 8'h01);
        rd(2'd1, v); chk("R7 flags readback", v, 8'h07);
        wr(2'd1, 8'h06);
        rd(2'd1, v); chk("R8 clear by zero", v, 8'h06);
        chk("R7 irq drops", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        int_pin = 1'b0; tick(3); int_pin = 1'b1; tick(3);
        int_pin = 1'b0;
        tick(2);
        wr(2'd1, 8'h06);
        rd(2'd1, v); chk("R9 set beats clear", flag_bit(v), 8'h01);
        chk("R9 irq stays", {7'd0, irq}, 8'h01);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R8 final clear", v, 8'h00);
        int_pin = 1'b1; tick(3);
    endtask

    task automatic t_edge_modes();
        logic [7:0] v;
        for (int s = 1; s < 4; s++) begin
            logic [1:0] sel = 2'(s);
            wr(2'd0, 8'h80 | {3'd0, sel, 3'd0});
            int_pin = 1'b0;
            tick(2); chk($sformatf("R11 int wake sel=%0d", s), {7'd0, wakeup}, {7'd0, sel[1]});
            tick(1); rd(2'd1, v);
            chk($sformatf("R4 fall sel=%0d", s), flag_bit(v), {7'd0, sel[1]});
            chk($sformatf("R11 wake pulse ends sel=%0d", s), {7'd0, wakeup}, 8'h00);
            wr(2'd1, 8'h00);
            int_pin = 1'b1;
            tick(3); rd(2'd1, v);
            chk($sformatf("R4 rise sel=%0d", s), flag_bit(v), {7'd0, sel[0]});
            wr(2'd1, 8'h00);
        end
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr(2'd0, 8'h80);
        int_pin = 1'b0;
        tick(2); chk("R5 no wake", {7'd0, wakeup}, 8'h00);
        tick(1); rd(2'd1, v); chk("R5 no flag on fall", flag_bit(v), 8'h00);
        int_pin = 1'b1;
        tick(3); rd(2'd1, v); chk("R5 no flag on rise", flag_bit(v), 8'h00);
    endtask

    task automatic t_edge_ports();
        wr(2'd0, 8'h98);
        p1_pins[1] = 1'b0;
        tick(2); chk("R11 p1 fall wake", {7'd0, wakeup}, 8'h01);
        tick(1); chk("R11 p1 wake one cycle", {7'd0, wakeup}, 8'h00);
        p1_pins[1] = 1'b1;
        tick(2); chk("R11 p1 rise wake", {7'd0, wakeup}, 8'h01);
        tick(1);
        p0_pins[0] = 1'b0;
        tick(2); chk("R11 p0 low wake", {7'd0, wakeup}, 8'h01);
        tick(2); chk("R11 p0 low holds", {7'd0, wakeup}, 8'h01);
        p0_pins[0] = 1'b1;
        tick(2); chk("R11 p0 released", {7'd0, wakeup}, 8'h00);
    endtask

    task automatic t_legacy_ports();
        wr(2'd0, 8'h00);
        p1_pins[2] = 1'b0;
        tick(2); chk("R10 p1 low wake", {7'd0, wakeup}, 8'h01);
        tick(2); chk("R10 p1 low holds", {7'd0, wakeup}, 8'h01);
        p1_pins[2] = 1'b1;
        tick(2); chk("R10 p1 released", {7'd0, wakeup}, 8'h00);
        p0_pins[1] = 1'b0;
        tick(2); chk("R10 p0 low wake", {7'd0, wakeup}, 8'h01);
        p0_pins[1] = 1'b1;
        tick(2); chk("R10 p0 released", {7'd0, wakeup}, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_ctrl_rw();
        t_legacy_int();
        t_irq_gate();
        t_set_wins();
        t_edge_modes();
        t_reserved();
        t_edge_ports();
        t_legacy_ports();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule